// File: doc/BRIEF.md
# Host-Side DAC Command Sequencer

This block sits on the host side of a serial DAC and turns simple channel requests into 16-bit SPI frames. A request carries a direction (write or read), a channel index and, for writes, a value. The block accepts one request at a time on a valid/ready handshake and answers with a one-cycle done pulse, an error flag and, for reads, a 12-bit result.

Every frame is a 4-bit command in bits 15:12 and a 12-bit payload in bits 11:0, sent MSB first. Writes use the load-and-update command 1+3·ch with the value left-aligned in the payload (shifted left by 12−N for an N-bit part). Reads depend on whether the part's serial data output is wired. If it is, the block sends the read command 2+3·ch, releases chip select for a gap, then sends a no-op frame (command 0) and keeps the low 12 bits it receives. If it is not, the block answers from a per-channel copy of the last write that completed. Two-channel parts have a control register, and after reset they get one control frame (command 13). One-channel parts get none.

Top module: `dac_cmd_seq`

## Requirements
- R1: After reset, a two-channel configuration sends exactly one frame with command 13 before accepting any request. Its payload holds the readback-mode code in bits 11:10 and the clear-to-midscale option in bit 8, with all other payload bits zero. A one-channel configuration sends no frame after reset.
- R2: An accepted write of value v (0 ≤ v < 2^N) to channel c sends one frame whose command is 1+3·c and whose payload is v shifted left by 12−N. It then reports done with the error flag low.
- R3: A write with v ≥ 2^N reports done with the error flag high and sends no frame.
- R4: A request whose channel index is not below NUM_CH reports done with the error flag high and sends no frame. A one-channel configuration accepts only channel 0.
- R5: With readback available, a read of channel c sends a frame with command 2+3·c and a zero payload, then a frame with command 0 and a zero payload. The result is the low 12 bits of the word received during the second frame.
- R6: Between the two frames of a read, chip select stays high for at least two SCLK periods (4·SCLK_HALF clock cycles).
- R7: With readback unavailable, a read of a present channel reports done on the cycle after acceptance, with no SPI traffic. The result is the shadow value zero-extended to 12 bits.
- R8: The shadow value of each channel is zero after reset. It changes only when a write frame to that channel completes, so rejected requests leave it unchanged.
- R9: req_ready is low from the cycle after a request is accepted until the cycle after rsp_done. rsp_done is high for exactly one cycle per request.
- R10: Readback is available only for two-channel parts, and only when no configuration is given (HAS_CFG=0, control payload all zero) or the configured mode code is not 2'b11 (disabled).
- R11: SCLK idles low while chip select is high. A frame is 16 SCLK periods with chip select low. MOSI changes only while SCLK is low and MISO is sampled on each SCLK rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | CHAN_W | Channel index |
| req_wdata | input | DATA_W | Write value (unshifted) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (valid with rsp_done) |
| rsp_rdata | output | 12 | Read result (valid with rsp_done) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_miso | input | 1 | Serial data from the DAC |

## Verification
The bench builds four copies of the block:
- a two-channel 10-bit part with mode code 1 and clear-to-midscale set, which covers the full control word and the left shift by two;
- a two-channel 12-bit part with no configuration, which covers the all-zero control word and readback as the default;
- a one-channel 8-bit part, which covers the missing control frame, rejection of channel 1 and shadow reads;
- a two-channel 8-bit part with mode code 3, which covers shadow reads on a part that still gets a control frame.

A bus model of the DAC keeps its own registers and pads read replies with nonzero upper bits, so the 12-bit mask is exercised.

// File: rtl/dacseq_pkg.sv
`timescale 1ns/1ps
package dacseq_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int PAY_W   = FRAME_W - CMD_W;

  localparam logic [CMD_W-1:0] CMD_NOP  = 4'd0;
  localparam logic [CMD_W-1:0] CMD_CTRL = 4'd13;
  localparam logic [1:0]       MODE_NO_READBACK = 2'b11;

  typedef enum logic [2:0] {
    ST_INIT_GO,
    ST_INIT_WAIT,
    ST_IDLE,
    ST_WR,
    ST_RD_CMD,
    ST_RD_GAP,
    ST_RD_NOP,
    ST_RESP
  } seq_state_e;

  function automatic logic [CMD_W-1:0] load_cmd(input int ch);
    return CMD_W'(1 + 3 * ch);
  endfunction

  function automatic logic [CMD_W-1:0] fetch_cmd(input int ch);
    return CMD_W'(2 + 3 * ch);
  endfunction
endpackage

// File: rtl/dacseq_spi_frame.sv
`timescale 1ns/1ps
module dacseq_spi_frame #(
  parameter int SCLK_HALF = 2,
  parameter int FRAME_W   = 16,
  parameter int RX_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               done,
  output logic [RX_W-1:0]    rx,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(FRAME_W);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic               done_q, done_d;
  logic [DW-1:0]      div_q, div_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [RX_W-1:0]    rx_q, rx_d;
  logic               tick;

  assign tick = busy_q && (div_q == DIV_LAST);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cs_d   = 1'b0;
        sclk_d = 1'b0;
        tx_d   = word;
        div_d  = '0;
        bit_d  = '0;
      end
    end else if (!tick) begin
      div_d = div_q + 1'b1;
    end else begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[RX_W-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == BIT_LAST) begin
          busy_d = 1'b0;
          cs_d   = 1'b1;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
      div_q  <= div_d;
      if (busy_d) bit_q <= bit_d;
      if (start || tick) tx_q <= tx_d;
      if (tick) rx_q <= rx_d;
    end
  end

  assign done = done_q;
  assign rx   = rx_q;
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = tx_q[FRAME_W-1];
endmodule

// File: rtl/dacseq_shadow.sv
`timescale 1ns/1ps
module dacseq_shadow #(
  parameter int NUM_CH   = 2,
  parameter int RES_BITS = 12,
  parameter int CHAN_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CHAN_W-1:0]   wr_chan,
  input  logic [RES_BITS-1:0] wr_val,
  input  logic [CHAN_W-1:0]   rd_chan,
  output logic [RES_BITS-1:0] rd_val
);
  logic [RES_BITS-1:0] val_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    logic hit;
    assign hit = we && (int'(wr_chan) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q[g] <= '0;
      else if (hit) val_q[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(rd_chan) == i) rd_val = val_q[i];
    end
  end
endmodule

// File: rtl/dacseq_ctrl.sv
`timescale 1ns/1ps
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int              NUM_CH    = 2,
  parameter int              RES_BITS  = 12,
  parameter int              CHAN_W    = 2,
  parameter int              DATA_W    = 16,
  parameter bit              HAS_CTRL  = 1'b1,
  parameter bit              READBACK  = 1'b1,
  parameter logic [11:0]     CTRL_WORD = 12'h000,
  parameter int              GAP_CYC   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic [PAY_W-1:0]    rsp_rdata,
  output logic                tx_start,
  output logic [FRAME_W-1:0]  tx_word,
  input  logic                tx_done,
  input  logic [PAY_W-1:0]    rx_word,
  output logic                sh_we,
  output logic [CHAN_W-1:0]   sh_chan,
  output logic [RES_BITS-1:0] sh_val,
  output logic [CHAN_W-1:0]   sh_rd_chan,
  input  logic [RES_BITS-1:0] sh_rd_val
);
  localparam int SHIFT = PAY_W - RES_BITS;
  localparam int GW    = $clog2(GAP_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
  localparam seq_state_e ST_RESET = HAS_CTRL ? ST_INIT_GO : ST_IDLE;

  seq_state_e          st_q, st_d;
  logic [CHAN_W-1:0]   chan_q, chan_d;
  logic [RES_BITS-1:0] val_q, val_d;
  logic                err_q, err_d;
  logic [PAY_W-1:0]    rdata_q, rdata_d;
  logic [GW-1:0]       gap_q, gap_d;
  logic                chan_ok, val_ok;
  logic [PAY_W-1:0]    wr_pay;

  assign chan_ok    = int'(req_chan) < NUM_CH;
  assign val_ok     = (req_wdata >> RES_BITS) == '0;
  assign wr_pay     = PAY_W'(req_wdata[RES_BITS-1:0]) << SHIFT;
  assign sh_rd_chan = req_chan;

  always_comb begin
    st_d     = st_q;
    chan_d   = chan_q;
    val_d    = val_q;
    err_d    = err_q;
    rdata_d  = rdata_q;
    gap_d    = gap_q;
    tx_start = 1'b0;
    tx_word  = '0;
    sh_we    = 1'b0;
    case (st_q)
      ST_INIT_GO: begin
        tx_start = 1'b1;
        tx_word  = {CMD_CTRL, CTRL_WORD};
        st_d     = ST_INIT_WAIT;
      end
      ST_INIT_WAIT: if (tx_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (req_valid) begin
          chan_d  = req_chan;
          err_d   = 1'b0;
          rdata_d = '0;
          if (!chan_ok || (req_write && !val_ok)) begin
            err_d = 1'b1;
            st_d  = ST_RESP;
          end else if (req_write) begin
            val_d    = req_wdata[RES_BITS-1:0];
            tx_start = 1'b1;
            tx_word  = {load_cmd(int'(req_chan)), wr_pay};
            st_d     = ST_WR;
          end else if (READBACK) begin
            tx_start = 1'b1;
            tx_word  = {fetch_cmd(int'(req_chan)), {PAY_W{1'b0}}};
            st_d     = ST_RD_CMD;
          end else begin
            rdata_d = PAY_W'(sh_rd_val);
            st_d    = ST_RESP;
          end
        end
      end
      ST_WR: begin
        if (tx_done) begin
          sh_we = 1'b1;
          st_d  = ST_RESP;
        end
      end
      ST_RD_CMD: begin
        if (tx_done) begin
          gap_d = '0;
          st_d  = ST_RD_GAP;
        end
      end
      ST_RD_GAP: begin
        gap_d = gap_q + 1'b1;
        if (gap_q == GAP_LAST) begin
          tx_start = 1'b1;
          tx_word  = {CMD_NOP, {PAY_W{1'b0}}};
          st_d     = ST_RD_NOP;
        end
      end
      ST_RD_NOP: begin
        if (tx_done) begin
          rdata_d = rx_word;
          st_d    = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      chan_q  <= '0;
      val_q   <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      gap_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        chan_q  <= chan_d;
        val_q   <= val_d;
        err_q   <= err_d;
        rdata_q <= rdata_d;
      end else if (st_q == ST_RD_NOP) begin
        rdata_q <= rdata_d;
      end
      gap_q <= gap_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_done  = (st_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign sh_chan   = chan_q;
  assign sh_val    = val_q;
endmodule

// File: rtl/dac_cmd_seq.sv
`timescale 1ns/1ps
module dac_cmd_seq
  import dacseq_pkg::*;
#(
  parameter int         NUM_CH    = 2,
  parameter int         RES_BITS  = 12,
  parameter int         CHAN_W    = 2,
  parameter int         DATA_W    = 16,
  parameter bit         HAS_CFG   = 1'b1,
  parameter logic [1:0] SDO_MODE  = 2'b00,
  parameter bit         CLR_MID   = 1'b0,
  parameter int         SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [11:0]       rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam bit HAS_CTRL = (NUM_CH > 1);
  localparam bit READBACK = HAS_CTRL && (!HAS_CFG || (SDO_MODE != MODE_NO_READBACK));
  localparam logic [11:0] CTRL_WORD = HAS_CFG ? {SDO_MODE, 1'b0, CLR_MID, 8'h00} : 12'h000;
  localparam int GAP_CYC = 4 * SCLK_HALF;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                tx_start, tx_done;
  logic [FRAME_W-1:0]  tx_word;
  logic [PAY_W-1:0]    rx_word;
  logic                sh_we;
  logic [CHAN_W-1:0]   sh_chan, sh_rd_chan;
  logic [RES_BITS-1:0] sh_val, sh_rd_val;

  dacseq_ctrl #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .CHAN_W(CHAN_W), .DATA_W(DATA_W),
    .HAS_CTRL(HAS_CTRL), .READBACK(READBACK), .CTRL_WORD(CTRL_WORD), .GAP_CYC(GAP_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_write(req_write), .req_chan(req_chan), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tx_start(tx_start), .tx_word(tx_word), .tx_done(tx_done), .rx_word(rx_word),
    .sh_we(sh_we), .sh_chan(sh_chan), .sh_val(sh_val),
    .sh_rd_chan(sh_rd_chan), .sh_rd_val(sh_rd_val)
  );

  dacseq_spi_frame #(.SCLK_HALF(SCLK_HALF), .FRAME_W(FRAME_W), .RX_W(PAY_W)) spi_i (
    .clk(clk), .rst_n(rst_int_n), .start(tx_start), .word(tx_word), .done(tx_done),
    .rx(rx_word), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  dacseq_shadow #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .CHAN_W(CHAN_W)) shadow_i (
    .clk(clk), .rst_n(rst_int_n), .we(sh_we), .wr_chan(sh_chan), .wr_val(sh_val),
    .rd_chan(sh_rd_chan), .rd_val(sh_rd_val)
  );
endmodule

// File: rtl/dac_cmd_seq_chk.sv
`timescale 1ns/1ps
module dac_cmd_seq_chk #(
  parameter int         NUM_CH   = 2,
  parameter int         RES_BITS = 12,
  parameter int         CHAN_W   = 2,
  parameter int         DATA_W   = 16,
  parameter bit         HAS_CFG  = 1'b1,
  parameter logic [1:0] SDO_MODE = 2'b00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [CHAN_W-1:0] req_chan,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_done,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_mosi
);
  localparam bit RB = (NUM_CH > 1) && (!HAS_CFG || (SDO_MODE != 2'b11));

  logic accept, bad_chan, bad_val;
  assign accept   = req_valid && req_ready;
  assign bad_chan = int'(req_chan) >= NUM_CH;
  assign bad_val  = req_write && ((req_wdata >> RES_BITS) != '0);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3
  bad_value_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bad_chan && bad_val) |=> (spi_cs_n && rsp_done));

  // R4
  bad_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_chan) |=> (spi_cs_n && rsp_done));

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  if (!RB) begin : g_local
    // R7
    local_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && !bad_chan) |=> (rsp_done && spi_cs_n));
  end
endmodule

bind dac_cmd_seq dac_cmd_seq_chk #(
  .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .CHAN_W(CHAN_W), .DATA_W(DATA_W),
  .HAS_CFG(HAS_CFG), .SDO_MODE(SDO_MODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_chan(req_chan), .req_wdata(req_wdata),
  .rsp_done(rsp_done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/dacseq_tb_core.sv
`timescale 1ns/1ps
module dacseq_tb_core #(
  parameter int ID  = 0,
  parameter int NCH = 2,
  parameter int RES = 12,
  parameter bit CFG = 1'b1,
  parameter int SDO = 0,
  parameter bit MID = 1'b0
) (
  input  logic clk,
  output logic fin,
  output int   n_chk,
  output int   n_bad
);
  localparam int  HALF = 2;
  localparam bit  HASC = (NCH > 1);
  localparam bit  RB   = HASC && (!CFG || SDO != 3);
  localparam int  SH   = 12 - RES;
  localparam int  MAXV = (1 << RES) - 1;

  logic        rst_n, req_valid, req_ready, req_write;
  logic [1:0]  req_chan;
  logic [15:0] req_wdata;
  logic        rsp_done, rsp_err;
  logic [11:0] rsp_rdata;
  logic        sclk, cs_n, mosi, miso;

  dac_cmd_seq #(
    .NUM_CH(NCH), .RES_BITS(RES), .CHAN_W(2), .DATA_W(16), .HAS_CFG(CFG),
    .SDO_MODE(2'(SDO)), .CLR_MID(MID), .SCLK_HALF(HALF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_chan(req_chan), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  typedef struct { bit err; bit rd; logic [11:0] data; string rq; } exp_t;
  exp_t        rsp_q[$];
  logic [15:0] frm_q[$];
  logic [11:0] exp_dev [4];
  logic [11:0] exp_sh  [4];
  int          n_resp = 0;

  function automatic void chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cfg%0d actual=%0h expected=%0h", rq, ID, act, exp);
    end
  endfunction

  // DAC bus model
  logic [15:0] m_rx = '0, m_tx = '0, m_pend = '0;
  logic [11:0] m_reg [2] = '{12'h0, 12'h0};
  int          m_bits = 0;
  bit          armed = 0, gap_pend = 0;
  realtime     t_rd = 0;

  assign miso = m_tx[15];

  always @(negedge cs_n) if (armed) begin
    m_tx   = m_pend;
    m_bits = 0;
    if (gap_pend) begin
      gap_pend = 0;
      chk(($realtime - t_rd) / 4.0 >= 4 * HALF, "R6", int'(($realtime - t_rd) / 4.0), 4 * HALF);
    end
  end
  always @(posedge sclk) if (!cs_n) begin m_rx = {m_rx[14:0], mosi}; m_bits++; end
  always @(negedge sclk) if (!cs_n) m_tx = {m_tx[14:0], 1'b0};

  always @(posedge cs_n) if (armed) begin
    logic [15:0] e;
    string t;
    int c;
    chk(m_bits == 16, "R11", m_bits, 16);
    if (frm_q.size() == 0) chk(0, "R1/R3/R4/R7 unexpected frame", int'(m_rx), 0);
    else begin
      e = frm_q.pop_front();
      c = int'(e[15:12]);
      t = (c == 13) ? "R1/R10" : (c == 1 || c == 4) ? "R2" : "R5";
      chk(m_rx == e, t, int'(m_rx), int'(e));
    end
    c = int'(m_rx[15:12]);
    m_pend = 16'h0;
    if (c == 1 || c == 4) m_reg[(c - 1) / 3] = m_rx[11:0];
    if (c == 2 || c == 5) begin
      m_pend   = {4'hA, m_reg[(c - 2) / 3]};
      t_rd     = $realtime;
      gap_pend = 1;
    end
  end

  // monitor
  always @(negedge clk) if (rst_n && rsp_done) begin
    exp_t e;
    chk(!req_ready, "R9", int'(req_ready), 0);
    if (rsp_q.size() == 0) chk(0, "R9 extra done", 1, 0);
    else begin
      e = rsp_q.pop_front();
      chk(rsp_err == e.err, e.rq, int'(rsp_err), int'(e.err));
      if (e.rd && !e.err) chk(rsp_rdata == e.data, e.rq, int'(rsp_rdata), int'(e.data));
    end
    n_resp++;
  end

  task automatic issue(bit wr, int ch, int val, string rq);
    exp_t e;
    int   target;
    e.rd = !wr; e.rq = rq; e.data = 12'h0;
    e.err = !(ch < NCH && (!wr || val <= MAXV));
    if (!e.err) begin
      if (wr) begin
        frm_q.push_back({4'(1 + 3 * ch), 12'(val << SH)});
        exp_dev[ch] = 12'(val << SH);
        exp_sh[ch]  = 12'(val);
      end else if (RB) begin
        frm_q.push_back({4'(2 + 3 * ch), 12'h0});
        frm_q.push_back(16'h0);
        e.data = exp_dev[ch];
      end else e.data = exp_sh[ch];
    end
    rsp_q.push_back(e);
    target = n_resp + 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_chan = 2'(ch); req_wdata = 16'(val);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9", int'(req_ready), 0);
    wait (n_resp >= target);
  endtask

  initial begin
    fin = 0; n_chk = 0; n_bad = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_chan = 0; req_wdata = 0;
    for (int i = 0; i < 4; i++) begin exp_dev[i] = 0; exp_sh[i] = 0; end
    if (HASC) frm_q.push_back({4'd13, (CFG ? {2'(SDO), 1'b0, MID} : 4'h0), 8'h00});
    repeat (3) @(negedge clk);
    armed = 1;
    chk(cs_n && !sclk && !rsp_done, "R11", int'({cs_n, sclk, rsp_done}), 4);
    rst_n = 1;
    repeat (4) @(negedge clk);
    while (!req_ready) @(negedge clk);
    issue(0, 0, 0, "R8");
    issue(1, 0, MAXV, "R2");
    issue(1, NCH - 1, 5, "R2");
    issue(0, 0, 0, RB ? "R5/R10" : "R7/R10");
    issue(0, NCH - 1, 0, RB ? "R5" : "R7");
    issue(1, 0, MAXV + 1, "R3");
    issue(0, 0, 0, "R8");
    issue(1, NCH, 3, "R4");
    issue(0, 3, 0, "R4");
    for (int i = 0; i < 4; i++) begin
      issue(1, i % NCH, (i * 37 + 11) % (MAXV + 1), "R2");
      issue(0, i % NCH, 0, RB ? "R5" : "R7");
    end
    repeat (40) @(negedge clk);
    chk(frm_q.size() == 0, "R1/R2/R5 missing frame", frm_q.size(), 0);
    chk(rsp_q.size() == 0, "R9 missing done", rsp_q.size(), 0);
    fin = 1;
  end
endmodule

// File: tb/dac_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dac_cmd_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic fa, fb, fc, fd;
  int   ca, cb, cc, cd, ba, bb, bc, bd;

  dacseq_tb_core #(.ID(0), .NCH(2), .RES(10), .CFG(1'b1), .SDO(1), .MID(1'b1))
    cfg_a (.clk(clk), .fin(fa), .n_chk(ca), .n_bad(ba));
  dacseq_tb_core #(.ID(1), .NCH(2), .RES(12), .CFG(1'b0), .SDO(0), .MID(1'b0))
    cfg_b (.clk(clk), .fin(fb), .n_chk(cb), .n_bad(bb));
  dacseq_tb_core #(.ID(2), .NCH(1), .RES(8), .CFG(1'b1), .SDO(0), .MID(1'b0))
    cfg_c (.clk(clk), .fin(fc), .n_chk(cc), .n_bad(bc));
  dacseq_tb_core #(.ID(3), .NCH(2), .RES(8), .CFG(1'b1), .SDO(3), .MID(1'b0))
    cfg_d (.clk(clk), .fin(fd), .n_chk(cd), .n_bad(bd));

  initial begin
    int tot, bad;
    bit hung;
    hung = 1;
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (fa && fb && fc && fd) begin hung = 0; break; end
    end
    @(negedge clk);
    tot = ca + cb + cc + cd;
    bad = ba + bb + bc + bd;
    if (hung) begin
      tot++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", tot, bad);
    $finish;
  end
endmodule